// File: doc/BRIEF.md
# Superscalar Decode Stage with Group Skid Buffer

This stage sits between instruction fetch and register rename in a multi-issue pipeline. Each cycle it may receive a group of up to `W` instruction slots. It forwards the live slots to rename, packed into the lowest lanes, and drops the slots that fetch already marked as killed. For a direct unconditional branch it checks the target that the slot carries against the predicted next PC. When the two differ, it sends fetch a redirect and stops forwarding the rest of that group.

When rename, issue or commit asks for a stall, whole incoming groups are parked in a small FIFO of groups and fetch is held off. Once the stalls clear, the parked groups are replayed one per cycle, oldest first, before fetch is released. A squash from commit, or a reorder-buffer squash indication, discards everything parked. Forwarding then halts until both indications drop. Seven activity counters and a sticky overflow flag record what the stage did. Every output is registered, so each result appears one clock after the cycle that produced it.

Top module: `dec_stage`

## Requirements
- R1: After reset all outputs are zero. This covers the rename lanes, the fetch stall, the redirect, every counter and the overflow flag. The stage starts in its idle state.
- R2: Fetch slot `i` occupies `fetch_grp_i[i*44 +: 44]`. Its fields, from MSB to LSB, are: valid (1 bit), killed (1), no-source-operands (1), direct-unconditional-branch (1), predicted next PC (16), branch target (16) and sequence number (8). In a cycle with no stall and no squash, every valid and not-killed slot appears one cycle later on the rename lanes. The slots keep their order and are packed from lane 0 upward. Each lane carries the ready flag (equal to no-source-operands), the next PC and the sequence number. For a slot that is not a branch, the next PC is the predicted PC.
- R3: A valid slot that is killed is never sent to rename, and it adds one to the killed counter. Each forwarded slot adds one to the decoded counter.
- R4: In a running or idle cycle with any downstream stall and no squash, nothing is forwarded. A valid group in that cycle is parked, and the fetch stall output is high from the next cycle. Every blocked cycle that also has a valid group parks that group.
- R5: A commit squash or a reorder-buffer squash empties the parked groups and puts the stage into squashing, even when a stall is asserted in the same cycle. While squashing, nothing is forwarded and fetch is not stalled. The stage returns to running in the first cycle in which neither indication is present.
- R6: After the stalls clear, the stage forwards one parked group per cycle, oldest first. Any valid group that arrives during this time is parked behind the others. The fetch stall stays high until the last parked group has been forwarded.
- R7: For a direct unconditional branch slot, the lane's next PC is the branch target. If the target differs from the predicted PC, the branch slot is still forwarded, but the later slots of the group are dropped. One cycle later the redirect is high, with the target as the PC and the branch's sequence number. The stage enters squashing and the mispredict counter increments.
- R8: Each cycle adds one to exactly the matching activity counter. The blocked, unblocking and squashing counters each count cycles spent in their state. The idle counter counts running or idle cycles with no valid group, no stall and no squash.
- R9: Parking a group while `DEPTH` groups are already held drops that group and sets the overflow flag. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_grp_i | input | W*44 | Fetch group, slot layout as in R2 |
| ren_stall_i | input | 1 | Stall request from rename |
| iss_stall_i | input | 1 | Stall request from issue |
| cmt_stall_i | input | 1 | Stall request from commit |
| cmt_squash_i | input | 1 | Squash from commit |
| rob_squash_i | input | 1 | Reorder buffer squashing |
| ren_vld_o | output | W | Rename lane valid bits |
| ren_rdy_o | output | W | Rename lane ready-to-issue bits |
| ren_npc_o | output | W*16 | Rename lane next PCs |
| ren_seq_o | output | W*8 | Rename lane sequence numbers |
| fq_stall_o | output | 1 | Stall to fetch |
| redir_o | output | 1 | Redirect to fetch: mispredict, squash and taken together |
| redir_pc_o | output | 16 | Corrected fetch PC |
| redir_seq_o | output | 8 | Sequence number of the mispredicted branch |
| cnt_idle_o | output | CNT_W | Idle cycle counter |
| cnt_blk_o | output | CNT_W | Blocked cycle counter |
| cnt_unblk_o | output | CNT_W | Unblocking cycle counter |
| cnt_sq_o | output | CNT_W | Squashing cycle counter |
| cnt_dec_o | output | CNT_W | Forwarded slot counter |
| cnt_sqi_o | output | CNT_W | Killed slot counter |
| cnt_misp_o | output | CNT_W | Branch mispredict counter |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Each rename lane, stall, redirect and counter value is due exactly one clock after the cycle whose inputs caused it. A replayed group is due one clock after the cycle in which the stage was unblocking with that group at the head of the FIFO. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so each reading reflects the inputs of the clock edge in between. Stall, replay and squash scenarios are stepped one cycle at a time, and each cycle's expected lane contents and stall level are written out. Counter results are checked as differences from values read just before each scenario.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int PC_W  = 16;
    localparam int SEQ_W = 8;

    typedef struct packed {
        logic             vld;
        logic             killed;
        logic             nosrc;
        logic             dubr;
        logic [PC_W-1:0]  pred_pc;
        logic [PC_W-1:0]  tgt_pc;
        logic [SEQ_W-1:0] seq;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } dstate_e;

endpackage

// File: rtl/dec_skid.sv
module dec_skid
    import dec_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic                        pop_i,
    input  logic                        flush_i,
    input  logic [W*SLOT_W-1:0]         din_i,
    output logic [W*SLOT_W-1:0]         head_o,
    output logic [$clog2(DEPTH+1)-1:0]  cnt_o,
    output logic                        drop_o
);
    localparam int GW    = W * SLOT_W;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][GW-1:0] mem;
        logic [PTR_W-1:0]         rd;
        logic [PTR_W-1:0]         wr;
        logic [CW-1:0]            cnt;
    } skid_t;

    skid_t skid_d, skid_q;
    logic  do_pop, do_push;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        skid_d  = skid_q;
        do_pop  = pop_i && (skid_q.cnt != '0);
        do_push = push_i && ((skid_q.cnt != CW'(DEPTH)) || do_pop);
        drop_o  = push_i && !do_push && !flush_i;
        if (flush_i) begin
            skid_d.rd  = '0;
            skid_d.wr  = '0;
            skid_d.cnt = '0;
        end else begin
            if (do_push) begin
                skid_d.mem[skid_q.wr] = din_i;
                skid_d.wr             = bump(skid_q.wr);
            end
            if (do_pop) begin
                skid_d.rd = bump(skid_q.rd);
            end
            case ({do_push, do_pop})
                2'b10:   skid_d.cnt = skid_q.cnt + CW'(1);
                2'b01:   skid_d.cnt = skid_q.cnt - CW'(1);
                default: skid_d.cnt = skid_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) skid_q <= '0;
        else        skid_q <= skid_d;
    end

    assign head_o = skid_q.mem[skid_q.rd];
    assign cnt_o  = skid_q.cnt;

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skid_q.cnt <= CW'(DEPTH));

    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (skid_q.cnt == '0));

endmodule

// File: rtl/dec_group.sv
module dec_group
    import dec_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W*SLOT_W-1:0]     grp_i,
    output logic [W-1:0]            vld_o,
    output logic [W-1:0]            rdy_o,
    output logic [W*PC_W-1:0]       npc_o,
    output logic [W*SEQ_W-1:0]      seq_o,
    output logic [$clog2(W+1)-1:0]  ndec_o,
    output logic [$clog2(W+1)-1:0]  nkill_o,
    output logic                    misp_o,
    output logic [PC_W-1:0]         mpc_o,
    output logic [SEQ_W-1:0]        mseq_o
);
    localparam int IDX_W = $clog2(W + 1);

    slot_t            s;
    logic             stop;
    logic [IDX_W-1:0] idx;

    always_comb begin
        vld_o   = '0;
        rdy_o   = '0;
        npc_o   = '0;
        seq_o   = '0;
        ndec_o  = '0;
        nkill_o = '0;
        misp_o  = 1'b0;
        mpc_o   = '0;
        mseq_o  = '0;
        stop    = 1'b0;
        idx     = '0;
        s       = '0;
        for (int i = 0; i < W; i++) begin
            s = slot_t'(grp_i[i*SLOT_W +: SLOT_W]);
            if (!stop && s.vld) begin
                if (s.killed) begin
                    nkill_o = nkill_o + IDX_W'(1);
                end else begin
                    vld_o[idx]               = 1'b1;
                    rdy_o[idx]               = s.nosrc;
                    npc_o[idx*PC_W +: PC_W]  = s.dubr ? s.tgt_pc : s.pred_pc;
                    seq_o[idx*SEQ_W +: SEQ_W] = s.seq;
                    idx    = idx + IDX_W'(1);
                    ndec_o = ndec_o + IDX_W'(1);
                    if (s.dubr && (s.tgt_pc != s.pred_pc)) begin
                        misp_o = 1'b1;
                        mpc_o  = s.tgt_pc;
                        mseq_o = s.seq;
                        stop   = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import dec_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W*44-1:0]      fetch_grp_i,
    input  logic                 ren_stall_i,
    input  logic                 iss_stall_i,
    input  logic                 cmt_stall_i,
    input  logic                 cmt_squash_i,
    input  logic                 rob_squash_i,
    output logic [W-1:0]         ren_vld_o,
    output logic [W-1:0]         ren_rdy_o,
    output logic [W*16-1:0]      ren_npc_o,
    output logic [W*8-1:0]       ren_seq_o,
    output logic                 fq_stall_o,
    output logic                 redir_o,
    output logic [15:0]          redir_pc_o,
    output logic [7:0]           redir_seq_o,
    output logic [CNT_W-1:0]     cnt_idle_o,
    output logic [CNT_W-1:0]     cnt_blk_o,
    output logic [CNT_W-1:0]     cnt_unblk_o,
    output logic [CNT_W-1:0]     cnt_sq_o,
    output logic [CNT_W-1:0]     cnt_dec_o,
    output logic [CNT_W-1:0]     cnt_sqi_o,
    output logic [CNT_W-1:0]     cnt_misp_o,
    output logic                 ovf_o
);
    localparam int GW    = W * SLOT_W;
    localparam int IDX_W = $clog2(W + 1);
    localparam int SK_CW = $clog2(DEPTH + 1);

    typedef struct packed {
        dstate_e            st;
        logic [W-1:0]       vld;
        logic [W-1:0]       rdy;
        logic [W*PC_W-1:0]  npc;
        logic [W*SEQ_W-1:0] seq;
        logic               stall;
        logic               redir;
        logic [PC_W-1:0]    rpc;
        logic [SEQ_W-1:0]   rseq;
        logic [CNT_W-1:0]   c_idle;
        logic [CNT_W-1:0]   c_blk;
        logic [CNT_W-1:0]   c_unblk;
        logic [CNT_W-1:0]   c_sq;
        logic [CNT_W-1:0]   c_dec;
        logic [CNT_W-1:0]   c_kill;
        logic [CNT_W-1:0]   c_misp;
        logic               ovf;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              sk_push, sk_pop, sk_flush, sk_drop;
    logic [GW-1:0]     sk_head, src_grp;
    logic [SK_CW-1:0]  sk_cnt;

    logic [W-1:0]       g_vld, g_rdy;
    logic [W*PC_W-1:0]  g_npc;
    logic [W*SEQ_W-1:0] g_seq;
    logic [IDX_W-1:0]   g_ndec, g_nkill;
    logic               g_misp;
    logic [PC_W-1:0]    g_mpc;
    logic [SEQ_W-1:0]   g_mseq;

    logic fv, stall_any, sq_any;

    dec_skid #(.W(W), .DEPTH(DEPTH)) u_skid (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (sk_push),
        .pop_i   (sk_pop),
        .flush_i (sk_flush),
        .din_i   (fetch_grp_i),
        .head_o  (sk_head),
        .cnt_o   (sk_cnt),
        .drop_o  (sk_drop)
    );

    assign src_grp = (regs_q.st == ST_UNBLK) ? sk_head : fetch_grp_i;

    dec_group #(.W(W)) u_group (
        .grp_i   (src_grp),
        .vld_o   (g_vld),
        .rdy_o   (g_rdy),
        .npc_o   (g_npc),
        .seq_o   (g_seq),
        .ndec_o  (g_ndec),
        .nkill_o (g_nkill),
        .misp_o  (g_misp),
        .mpc_o   (g_mpc),
        .mseq_o  (g_mseq)
    );

    always_comb begin
        fv = 1'b0;
        for (int i = 0; i < W; i++) begin
            fv = fv | fetch_grp_i[i*SLOT_W + SLOT_W - 1];
        end
    end

    assign stall_any = ren_stall_i | iss_stall_i | cmt_stall_i;
    assign sq_any    = cmt_squash_i | rob_squash_i;

    always_comb begin
        regs_d       = regs_q;
        regs_d.vld   = '0;
        regs_d.rdy   = '0;
        regs_d.npc   = '0;
        regs_d.seq   = '0;
        regs_d.redir = 1'b0;
        regs_d.rpc   = '0;
        regs_d.rseq  = '0;
        sk_push      = 1'b0;
        sk_pop       = 1'b0;
        sk_flush     = 1'b0;

        if (regs_q.st == ST_UNBLK) regs_d.c_unblk = regs_q.c_unblk + CNT_W'(1);

        case (regs_q.st)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (sq_any) begin
                    sk_flush  = 1'b1;
                    regs_d.st = ST_SQ;
                end else if (stall_any) begin
                    sk_push   = fv;
                    regs_d.st = ST_BLK;
                end else if ((regs_q.st != ST_UNBLK) && !fv) begin
                    regs_d.c_idle = regs_q.c_idle + CNT_W'(1);
                end else begin
                    regs_d.vld    = g_vld;
                    regs_d.rdy    = g_rdy;
                    regs_d.npc    = g_npc;
                    regs_d.seq    = g_seq;
                    regs_d.c_dec  = regs_q.c_dec + CNT_W'(g_ndec);
                    regs_d.c_kill = regs_q.c_kill + CNT_W'(g_nkill);
                    if (g_misp) begin
                        regs_d.redir  = 1'b1;
                        regs_d.rpc    = g_mpc;
                        regs_d.rseq   = g_mseq;
                        regs_d.c_misp = regs_q.c_misp + CNT_W'(1);
                        sk_flush      = 1'b1;
                        regs_d.st     = ST_SQ;
                    end else if (regs_q.st == ST_UNBLK) begin
                        sk_pop  = 1'b1;
                        sk_push = fv;
                        if ((sk_cnt == SK_CW'(1)) && !fv) regs_d.st = ST_RUN;
                    end else begin
                        regs_d.st = ST_RUN;
                    end
                end
            end
            ST_BLK: begin
                regs_d.c_blk = regs_q.c_blk + CNT_W'(1);
                if (sq_any) begin
                    sk_flush  = 1'b1;
                    regs_d.st = ST_SQ;
                end else begin
                    sk_push = fv;
                    if (!stall_any) begin
                        regs_d.st = ((sk_cnt == '0) && !fv) ? ST_RUN : ST_UNBLK;
                    end
                end
            end
            ST_SQ: begin
                regs_d.c_sq = regs_q.c_sq + CNT_W'(1);
                if (sq_any) sk_flush  = 1'b1;
                else        regs_d.st = ST_RUN;
            end
            default: regs_d.st = ST_IDLE;
        endcase

        regs_d.stall = (regs_d.st == ST_BLK) || (regs_d.st == ST_UNBLK);
        regs_d.ovf   = regs_q.ovf | sk_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ren_vld_o   = regs_q.vld;
    assign ren_rdy_o   = regs_q.rdy;
    assign ren_npc_o   = regs_q.npc;
    assign ren_seq_o   = regs_q.seq;
    assign fq_stall_o  = regs_q.stall;
    assign redir_o     = regs_q.redir;
    assign redir_pc_o  = regs_q.rpc;
    assign redir_seq_o = regs_q.rseq;
    assign cnt_idle_o  = regs_q.c_idle;
    assign cnt_blk_o   = regs_q.c_blk;
    assign cnt_unblk_o = regs_q.c_unblk;
    assign cnt_sq_o    = regs_q.c_sq;
    assign cnt_dec_o   = regs_q.c_dec;
    assign cnt_sqi_o   = regs_q.c_kill;
    assign cnt_misp_o  = regs_q.c_misp;
    assign ovf_o       = regs_q.ovf;

    assert_lanes_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_vld_o & (ren_vld_o + W'(1))) == '0);

    assert_stall_when_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_BLK) |-> fq_stall_o);

    assert_squash_enters_sq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_squash_i || rob_squash_i) |=> (regs_q.st == ST_SQ));

    assert_sq_no_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_SQ) |=> (ren_vld_o == '0));

    assert_redir_flushed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (sk_cnt == '0));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

endmodule

// File: tb/dec_stage_bench.sv
`timescale 1ns/1ps
module dec_stage_bench;
    localparam int W  = 4;
    localparam int SW = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W*SW-1:0] grp = '0;
    logic rs = 0, is_ = 0, cs = 0, csq = 0, rsq = 0;
    logic [W-1:0]    ren_vld, ren_rdy;
    logic [W*16-1:0] ren_npc;
    logic [W*8-1:0]  ren_seq;
    logic            fq_stall, redir, ovf;
    logic [15:0]     redir_pc;
    logic [7:0]      redir_seq;
    logic [15:0]     c_idle, c_blk, c_unblk, c_sq, c_dec, c_sqi, c_misp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dec_stage u_dec_stage (
        .clk(clk), .rst_n(rst_n), .fetch_grp_i(grp),
        .ren_stall_i(rs), .iss_stall_i(is_), .cmt_stall_i(cs),
        .cmt_squash_i(csq), .rob_squash_i(rsq),
        .ren_vld_o(ren_vld), .ren_rdy_o(ren_rdy), .ren_npc_o(ren_npc), .ren_seq_o(ren_seq),
        .fq_stall_o(fq_stall), .redir_o(redir), .redir_pc_o(redir_pc), .redir_seq_o(redir_seq),
        .cnt_idle_o(c_idle), .cnt_blk_o(c_blk), .cnt_unblk_o(c_unblk), .cnt_sq_o(c_sq),
        .cnt_dec_o(c_dec), .cnt_sqi_o(c_sqi), .cnt_misp_o(c_misp), .ovf_o(ovf)
    );

    function automatic logic [SW-1:0] slot(input logic v, input logic k, input logic ns,
                                           input logic br, input logic [15:0] p,
                                           input logic [15:0] t, input logic [7:0] s);
        return {v, k, ns, br, p, t, s};
    endfunction

    function automatic logic [W*SW-1:0] one(input logic [7:0] s);
        logic [W*SW-1:0] g = '0;
        g[SW-1:0] = slot(1'b1, 1'b0, 1'b0, 1'b0, {8'h02, s}, 16'h0, s);
        return g;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk_one(input string req, input logic [7:0] s, input logic st);
        chk(ren_vld == 4'b0001 && ren_seq[7:0] == s && fq_stall == st, req,
            {ren_vld, ren_seq[7:0], 3'b0, fq_stall}, {4'b0001, s, 3'b0, st});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] b_idle, b_blk, b_unblk, b_sq, b_dec, b_sqi, b_misp;
        int e_dec, e_kill;
        logic [W-1:0]    e_vld, e_rdy;
        logic [W*16-1:0] e_npc;
        logic [W*8-1:0]  e_seq;

        repeat (3) cyc();
        // R1: reset state
        chk(ren_vld == 0 && ren_rdy == 0 && ren_npc == 0 && ren_seq == 0, "R1 lanes",
            {ren_vld, ren_rdy, ren_seq}, 0);
        chk(fq_stall == 0 && redir == 0 && ovf == 0, "R1 flags", {fq_stall, redir, ovf}, 0);
        chk(c_idle == 0 && c_blk == 0 && c_unblk == 0 && c_sq == 0 && c_dec == 0 &&
            c_sqi == 0 && c_misp == 0, "R1 counters",
            {c_idle, c_blk, c_unblk, c_sq, c_dec, c_sqi, c_misp}, 0);
        rst_n = 1'b1;
        cyc();

        // R2 R3 R8: sweep every valid and killed pattern
        b_idle = c_idle; b_dec = c_dec; b_sqi = c_sqi;
        e_dec = 0; e_kill = 0;
        for (int vm = 0; vm < 16; vm++) begin
            for (int km = 0; km < 16; km++) begin
                int k;
                grp = '0;
                e_vld = '0; e_rdy = '0; e_npc = '0; e_seq = '0; k = 0;
                for (int i = 0; i < W; i++) begin
                    grp[i*SW +: SW] = slot(vm[i], km[i], i[0], 1'b0, 16'(16'h100 + i), 16'hBEEF,
                                           8'(8'h10 * vm + 8'(i)));
                    if (vm[i] && km[i]) e_kill++;
                    if (vm[i] && !km[i]) begin
                        e_vld[k] = 1'b1;
                        e_rdy[k] = i[0];
                        e_npc[k*16 +: 16] = 16'(16'h100 + i);
                        e_seq[k*8 +: 8] = 8'(8'h10 * vm + 8'(i));
                        k++;
                        e_dec++;
                    end
                end
                cyc();
                chk({ren_vld, ren_rdy, ren_npc, ren_seq} == {e_vld, e_rdy, e_npc, e_seq},
                    "R2 R3 sweep lanes", {ren_vld, ren_rdy, ren_npc, ren_seq},
                    {e_vld, e_rdy, e_npc, e_seq});
            end
        end
        grp = '0;
        chk(c_dec - b_dec == 16'(e_dec), "R3 decoded count", c_dec - b_dec, e_dec);
        chk(c_sqi - b_sqi == 16'(e_kill), "R3 killed count", c_sqi - b_sqi, e_kill);
        chk(c_idle - b_idle == 16, "R8 idle count", c_idle - b_idle, 16);

        // R4 R6: park three groups, replay with one arriving behind
        b_blk = c_blk; b_unblk = c_unblk;
        grp = one(8'hA1); rs = 1; cyc();
        chk(fq_stall == 1 && ren_vld == 0, "R4 stall entry", {fq_stall, ren_vld}, 5'b10000);
        grp = one(8'hB1); cyc();
        chk(fq_stall == 1 && ren_vld == 0, "R4 blocked park", {fq_stall, ren_vld}, 5'b10000);
        grp = one(8'hC1); rs = 0; is_ = 1; cyc();
        grp = '0; is_ = 0; cyc();
        chk(fq_stall == 1 && ren_vld == 0, "R6 stall held on release", {fq_stall, ren_vld}, 5'b10000);
        cyc();
        chk_one("R6 replay oldest", 8'hA1, 1'b1);
        grp = one(8'hD1); cyc();
        chk_one("R6 replay second", 8'hB1, 1'b1);
        grp = '0; cyc();
        chk_one("R6 replay third", 8'hC1, 1'b1);
        cyc();
        chk_one("R6 late group last", 8'hD1, 1'b0);
        chk(c_blk - b_blk == 3, "R8 blocked count", c_blk - b_blk, 3);
        chk(c_unblk - b_unblk == 4, "R8 unblocking count", c_unblk - b_unblk, 4);
        grp = one(8'hE1); cyc();
        chk_one("R2 resumed direct", 8'hE1, 1'b0);
        chk(ovf == 0, "R9 no overflow yet", ovf, 0);

        // R9 R5: overflow then squash with stall present
        b_sq = c_sq;
        cs = 1;
        for (int j = 0; j < 4; j++) begin
            grp = one(8'(8'h50 + j)); cyc();
        end
        chk(ovf == 0, "R9 full without overflow", ovf, 0);
        grp = one(8'h54); cyc();
        chk(ovf == 1, "R9 overflow set", ovf, 1);
        grp = one(8'h60); csq = 1; cyc();
        chk(fq_stall == 0 && ren_vld == 0, "R5 squash beats stall", {fq_stall, ren_vld}, 0);
        grp = '0; cyc();
        csq = 0; cs = 0; cyc();
        chk(fq_stall == 0 && ren_vld == 0, "R5 squashing silent", {fq_stall, ren_vld}, 0);
        chk(c_sq - b_sq == 2, "R8 squashing count", c_sq - b_sq, 2);
        grp = one(8'h61); cyc();
        chk_one("R5 buffer emptied", 8'h61, 1'b0);
        chk(ovf == 1, "R9 overflow sticky", ovf, 1);

        // R5: reorder buffer squash
        grp = one(8'h70); rsq = 1; cyc();
        chk(ren_vld == 0 && fq_stall == 0, "R5 rob squash drops", {fq_stall, ren_vld}, 0);
        grp = '0; rsq = 0; cyc();
        grp = one(8'h71); cyc();
        chk_one("R5 rob squash exit", 8'h71, 1'b0);

        // R7: mispredicted direct branch
        b_misp = c_misp;
        grp[0*SW +: SW] = slot(1, 0, 1, 0, 16'h0300, 16'h0, 8'hB0);
        grp[1*SW +: SW] = slot(1, 0, 0, 1, 16'h0310, 16'h0310, 8'hB1);
        grp[2*SW +: SW] = slot(1, 0, 0, 1, 16'h0320, 16'h03A0, 8'hB2);
        grp[3*SW +: SW] = slot(1, 0, 0, 0, 16'h0330, 16'h0, 8'hB3);
        cyc();
        chk(ren_vld == 4'b0111 && ren_rdy == 4'b0001, "R7 lanes up to branch",
            {ren_vld, ren_rdy}, 8'h71);
        chk(ren_npc[47:0] == {16'h03A0, 16'h0310, 16'h0300} && ren_seq[23:0] == 24'hB2B1B0,
            "R7 target as next PC", {ren_npc[47:0], ren_seq[23:0]},
            {48'h03A0_0310_0300, 24'hB2B1B0});
        chk(redir == 1 && redir_pc == 16'h03A0 && redir_seq == 8'hB2, "R7 redirect",
            {redir, redir_pc, redir_seq}, {1'b1, 16'h03A0, 8'hB2});
        chk(c_misp - b_misp == 1, "R7 mispredict count", c_misp - b_misp, 1);
        grp = '0; cyc();
        chk(redir == 0 && ren_vld == 0, "R7 squashing after redirect", {redir, ren_vld}, 0);
        grp = one(8'hC7); cyc();
        chk_one("R7 resume after squash", 8'hC7, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule